// File: doc/BRIEF.md
# Memory Command Priority Arbiter

This block sits ahead of a DRAM interface controller and chooses which command the controller runs next. After reset it issues a single initialization command and waits for it to finish. From then on it picks one command at a time. A due refresh comes first, a packet waiting in the input buffer comes next, and a read requested by the scheduler comes last. When nothing is pending it stays idle.

Every issued command is announced with a one-cycle strobe. Its code and burst length stay on the outputs until the controller returns a completion pulse. No further decision is taken until that pulse arrives. When the arbiter picks a write, it raises a one-cycle permit so that the input buffer hands over one whole packet. When it picks a read, it raises a one-cycle grant to the scheduler. A reloadable down-counter, loaded from a programmable interval, makes refreshes due. The counter restarts each time a refresh completes.

Top module: `mem_cmd_arbiter`

## Requirements
- R1: While `rst` is high at a clock edge, the outputs after that edge are `cmd_valid`=0, `cmd_code`=0 (idle), `cmd_beats`=0, `wr_permit`=0 and `rd_grant`=0.
- R2: The first command issued after reset is initialization (code 1). It is issued at the first clock edge with `rst` low.
- R3: Until the initialization command has been completed by `ctrl_done`, no refresh, write or read is issued, even when one is requested.
- R4: After initialization, each decision picks refresh (code 2) when one is due, otherwise write (code 3) when `wr_pkt_ready` is high, otherwise read (code 4) when `rd_req` is high.
- R5: `cmd_valid` is high for exactly one cycle per issued command, in the first cycle that shows the new code.
- R6: `cmd_code` and `cmd_beats` hold their values from issue until the cycle in which `ctrl_done` is seen. In the next cycle they return to idle (code 0, beats 0). A new command is strobed no earlier than the cycle after that.
- R7: A write raises `wr_permit` in the strobe cycle only, with `cmd_beats` = PKT_BEATS (a whole packet).
- R8: A read raises `rd_grant` in the strobe cycle only, with `cmd_beats` = RD_BEATS. Initialization and refresh carry 0 beats. Write and read bursts are never shorter than 2 beats.
- R9: The refresh counter loads `refresh_interval` at reset and when a refresh's `ctrl_done` is seen. It counts down once per cycle to zero, and a refresh is due while it is zero. With no other traffic, consecutive refresh strobes are therefore `refresh_interval` + d + 2 cycles apart, where `ctrl_done` arrives d+1 cycles after the strobe.
- R10: With initialization done and no request pending, no command is strobed and `cmd_code` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| refresh_interval | input | CNT_W | Refresh counter reload value in cycles |
| wr_pkt_ready | input | 1 | Input buffer holds at least one complete packet |
| rd_req | input | 1 | Scheduler requests a read burst |
| ctrl_done | input | 1 | Interface controller finished the current command |
| cmd_valid | output | 1 | One-cycle strobe for a new command |
| cmd_code | output | 3 | Current command: 0 idle, 1 init, 2 refresh, 3 write, 4 read |
| cmd_beats | output | BEAT_W | Burst length of the current command |
| wr_permit | output | 1 | One-cycle permit for the input buffer to send one packet |
| rd_grant | output | 1 | One-cycle grant to the scheduler for its read |

## Verification
The checker holds several rules on every cycle. The strobe is a single pulse, and no strobe comes while a command is still outstanding. Permit and grant pulses coincide with a write or read strobe. A command code stays fixed until completion. A write is never chosen while a refresh was due, and nothing but initialization is issued before initialization is done. Only the bench's scenarios can show the picked order when several requests are pending at once, the exact spacing of refreshes as a function of the programmed interval and completion latency, and that a quiet arbiter stays idle. The bench's cycle model covers all of these, including back-to-back traffic with zero-latency completion.

// File: rtl/mca_pkg.sv
package mca_pkg;

  typedef enum logic [2:0] {
    CMD_IDLE    = 3'd0,
    CMD_INIT    = 3'd1,
    CMD_REFRESH = 3'd2,
    CMD_WRITE   = 3'd3,
    CMD_READ    = 3'd4
  } mcmd_e;

  typedef enum logic [1:0] {
    PH_START = 2'd0,
    PH_READY = 2'd1,
    PH_BUSY  = 2'd2
  } phase_e;

endpackage

// File: rtl/mca_refresh_timer.sv
module mca_refresh_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] reload_len,
  input  logic             reload,
  output logic             due
);

  logic [CNT_W-1:0] remain_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      remain_q <= reload_len;
    end else if (reload) begin
      remain_q <= reload_len;
    end else if (remain_q != '0) begin
      remain_q <= remain_q - 1'b1;
    end
  end

  assign due = (remain_q == '0);

endmodule

// File: rtl/mca_priority_pick.sv
module mca_priority_pick
  import mca_pkg::*;
(
  input  logic  init_done,
  input  logic  refresh_due,
  input  logic  wr_pkt_ready,
  input  logic  rd_req,
  output mcmd_e pick,
  output logic  pick_any
);

  always_comb begin
    pick     = CMD_IDLE;
    pick_any = 1'b0;
    if (!init_done) begin
      pick     = CMD_INIT;
      pick_any = 1'b1;
    end else if (refresh_due) begin
      pick     = CMD_REFRESH;
      pick_any = 1'b1;
    end else if (wr_pkt_ready) begin
      pick     = CMD_WRITE;
      pick_any = 1'b1;
    end else if (rd_req) begin
      pick     = CMD_READ;
      pick_any = 1'b1;
    end
  end

endmodule

// File: rtl/mca_issue_fsm.sv
module mca_issue_fsm
  import mca_pkg::*;
#(
  parameter int BEAT_W    = 5,
  parameter int PKT_BEATS = 24,
  parameter int RD_BEATS  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  mcmd_e             pick,
  input  logic              pick_any,
  input  logic              ctrl_done,
  output logic              cmd_valid,
  output logic [2:0]        cmd_code,
  output logic [BEAT_W-1:0] cmd_beats,
  output logic              wr_permit,
  output logic              rd_grant,
  output logic              init_done,
  output logic              refresh_ack
);

  phase_e            phase_q;
  mcmd_e             code_q;
  logic [BEAT_W-1:0] beats_q;
  logic              valid_q, permit_q, grant_q, init_q;

  function automatic logic [BEAT_W-1:0] burst_of(input mcmd_e c);
    unique case (c)
      CMD_WRITE: burst_of = BEAT_W'(PKT_BEATS);
      CMD_READ:  burst_of = BEAT_W'(RD_BEATS);
      default:   burst_of = '0;
    endcase
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q  <= PH_START;
      code_q   <= CMD_IDLE;
      beats_q  <= '0;
      valid_q  <= 1'b0;
      permit_q <= 1'b0;
      grant_q  <= 1'b0;
      init_q   <= 1'b0;
    end else begin
      valid_q  <= 1'b0;
      permit_q <= 1'b0;
      grant_q  <= 1'b0;
      unique case (phase_q)
        PH_START, PH_READY: begin
          if (pick_any) begin
            valid_q  <= 1'b1;
            code_q   <= pick;
            beats_q  <= burst_of(pick);
            permit_q <= (pick == CMD_WRITE);
            grant_q  <= (pick == CMD_READ);
            phase_q  <= PH_BUSY;
          end
        end
        PH_BUSY: begin
          if (ctrl_done) begin
            if (code_q == CMD_INIT) init_q <= 1'b1;
            code_q  <= CMD_IDLE;
            beats_q <= '0;
            phase_q <= PH_READY;
          end
        end
        default: phase_q <= PH_START;
      endcase
    end
  end

  assign refresh_ack = (phase_q == PH_BUSY) && ctrl_done && (code_q == CMD_REFRESH);
  assign cmd_valid   = valid_q;
  assign cmd_code    = code_q;
  assign cmd_beats   = beats_q;
  assign wr_permit   = permit_q;
  assign rd_grant    = grant_q;
  assign init_done   = init_q;

endmodule

// File: rtl/mem_cmd_arbiter.sv
module mem_cmd_arbiter
  import mca_pkg::*;
#(
  parameter int CNT_W     = 16,
  parameter int PKT_BEATS = 24,
  parameter int RD_BEATS  = 8,
  localparam int MAX_BEATS = (PKT_BEATS > RD_BEATS) ? PKT_BEATS : RD_BEATS,
  localparam int BEAT_W    = $clog2(MAX_BEATS + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CNT_W-1:0]  refresh_interval,
  input  logic              wr_pkt_ready,
  input  logic              rd_req,
  input  logic              ctrl_done,
  output logic              cmd_valid,
  output logic [2:0]        cmd_code,
  output logic [BEAT_W-1:0] cmd_beats,
  output logic              wr_permit,
  output logic              rd_grant
);

  logic  refresh_due;
  logic  refresh_ack;
  logic  init_done;
  mcmd_e pick;
  logic  pick_any;

  mca_refresh_timer #(.CNT_W(CNT_W)) u_timer (
    .clk        (clk),
    .rst        (rst),
    .reload_len (refresh_interval),
    .reload     (refresh_ack),
    .due        (refresh_due)
  );

  mca_priority_pick u_pick (
    .init_done    (init_done),
    .refresh_due  (refresh_due),
    .wr_pkt_ready (wr_pkt_ready),
    .rd_req       (rd_req),
    .pick         (pick),
    .pick_any     (pick_any)
  );

  mca_issue_fsm #(
    .BEAT_W    (BEAT_W),
    .PKT_BEATS (PKT_BEATS),
    .RD_BEATS  (RD_BEATS)
  ) u_fsm (
    .clk         (clk),
    .rst         (rst),
    .pick        (pick),
    .pick_any    (pick_any),
    .ctrl_done   (ctrl_done),
    .cmd_valid   (cmd_valid),
    .cmd_code    (cmd_code),
    .cmd_beats   (cmd_beats),
    .wr_permit   (wr_permit),
    .rd_grant    (rd_grant),
    .init_done   (init_done),
    .refresh_ack (refresh_ack)
  );

endmodule

// File: rtl/mca_arbiter_chk.sv
module mca_arbiter_chk #(
  parameter int BEAT_W = 5
) (
  input logic              clk,
  input logic              rst,
  input logic              cmd_valid,
  input logic [2:0]        cmd_code,
  input logic [BEAT_W-1:0] cmd_beats,
  input logic              wr_permit,
  input logic              rd_grant,
  input logic              ctrl_done,
  input logic              refresh_due,
  input logic              init_done
);

  logic open_q;

  always_ff @(posedge clk) begin
    if (rst)            open_q <= 1'b0;
    else if (ctrl_done) open_q <= 1'b0;
    else if (cmd_valid) open_q <= 1'b1;
  end

  // R5
  strobe_single_chk: assert property (@(posedge clk) disable iff (rst)
    cmd_valid |=> !cmd_valid);

  // R6
  no_issue_while_open_chk: assert property (@(posedge clk) disable iff (rst)
    cmd_valid |-> !open_q);

  // R6
  code_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_code != 3'd0 && !ctrl_done) |=> (cmd_code == $past(cmd_code)));

  // R7
  permit_with_write_chk: assert property (@(posedge clk) disable iff (rst)
    wr_permit |-> (cmd_valid && cmd_code == 3'd3));

  // R8
  grant_with_read_chk: assert property (@(posedge clk) disable iff (rst)
    rd_grant |-> (cmd_valid && cmd_code == 3'd4));

  // R8
  burst_min_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && (cmd_code == 3'd3 || cmd_code == 3'd4)) |-> (cmd_beats >= 2));

  // R4
  write_not_over_refresh_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_code == 3'd3) |-> $past(!refresh_due));

  // R3
  init_first_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_code != 3'd1) |-> init_done);

endmodule

bind mem_cmd_arbiter mca_arbiter_chk #(.BEAT_W(BEAT_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .cmd_valid   (cmd_valid),
  .cmd_code    (cmd_code),
  .cmd_beats   (cmd_beats),
  .wr_permit   (wr_permit),
  .rd_grant    (rd_grant),
  .ctrl_done   (ctrl_done),
  .refresh_due (refresh_due),
  .init_done   (init_done)
);

// File: tb/tb_mem_cmd_arbiter.sv
module tb_mem_cmd_arbiter;

  localparam int CNT_W     = 16;
  localparam int PKT_BEATS = 24;
  localparam int RD_BEATS  = 8;
  localparam int BEAT_W    = $clog2(PKT_BEATS + 1);

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic [CNT_W-1:0]  refresh_interval = 16'd1000;
  logic              wr_pkt_ready, rd_req;
  logic              ctrl_done = 1'b0;
  logic              cmd_valid, wr_permit, rd_grant;
  logic [2:0]        cmd_code;
  logic [BEAT_W-1:0] cmd_beats;

  int wr_pkts = 0, rd_pkts = 0;
  assign wr_pkt_ready = (wr_pkts > 0);
  assign rd_req       = (rd_pkts > 0);

  mem_cmd_arbiter #(.CNT_W(CNT_W), .PKT_BEATS(PKT_BEATS), .RD_BEATS(RD_BEATS)) dut (
    .clk(clk), .rst(rst), .refresh_interval(refresh_interval),
    .wr_pkt_ready(wr_pkt_ready), .rd_req(rd_req), .ctrl_done(ctrl_done),
    .cmd_valid(cmd_valid), .cmd_code(cmd_code), .cmd_beats(cmd_beats),
    .wr_permit(wr_permit), .rd_grant(rd_grant)
  );

  always #4 clk = ~clk;

  int n_chk = 0, n_fail = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference model
  int m_phase, m_code, m_beats, m_cnt;
  bit m_valid, m_wp, m_rg, started;

  task automatic m_issue(input int c);
    m_valid = 1; m_code = c; m_phase = 2;
    m_wp = (c == 3); m_rg = (c == 4);
    m_beats = (c == 3) ? PKT_BEATS : (c == 4) ? RD_BEATS : 0;
  endtask

  always @(posedge clk) begin
    started = 1;
    if (rst) begin
      m_phase = 0; m_code = 0; m_beats = 0; m_cnt = int'(refresh_interval);
      m_valid = 0; m_wp = 0; m_rg = 0;
    end else begin
      bit due, ack;
      due = (m_cnt == 0);
      ack = (m_phase == 2) && ctrl_done && (m_code == 2);
      if (ack) m_cnt = int'(refresh_interval);
      else if (m_cnt > 0) m_cnt--;
      m_valid = 0; m_wp = 0; m_rg = 0;
      if (m_phase == 0) m_issue(1);
      else if (m_phase == 1) begin
        if (due) m_issue(2);
        else if (wr_pkt_ready) m_issue(3);
        else if (rd_req) m_issue(4);
      end else if (ctrl_done) begin
        m_code = 0; m_beats = 0; m_phase = 1;
      end
    end
  end

  // responder, traffic sources, logging and per-cycle comparison
  int lat_cfg = 3, lat_ctr = 0, cyc = 0;
  bit busy_tb = 0, init_open = 0;
  int early_cmds = 0, n_permit = 0, n_grant = 0, wr_beats_seen = -1, rd_beats_seen = -1;
  int issued_q[$];
  int refresh_cyc[$];

  always @(negedge clk) begin
    cyc++;
    if (started) begin
      chk(cmd_valid == m_valid, "R5 cmd_valid", int'(cmd_valid), int'(m_valid));
      chk(int'(cmd_code) == m_code, "R6 cmd_code", int'(cmd_code), m_code);
      chk(int'(cmd_beats) == m_beats, "R8 cmd_beats", int'(cmd_beats), m_beats);
      chk(wr_permit == m_wp, "R7 wr_permit", int'(wr_permit), int'(m_wp));
      chk(rd_grant == m_rg, "R8 rd_grant", int'(rd_grant), int'(m_rg));
    end
    ctrl_done = 1'b0;
    if (rst) begin
      busy_tb = 0; init_open = 0;
    end else begin
      if (cmd_valid) begin
        issued_q.push_back(int'(cmd_code));
        if (cmd_code == 3'd1) init_open = 1;
        else if (init_open) early_cmds++;
        if (cmd_code == 3'd2) refresh_cyc.push_back(cyc);
        if (cmd_code == 3'd3) wr_beats_seen = int'(cmd_beats);
        if (cmd_code == 3'd4) rd_beats_seen = int'(cmd_beats);
        busy_tb = 1; lat_ctr = lat_cfg;
      end
      if (wr_permit) begin n_permit++; if (wr_pkts > 0) wr_pkts--; end
      if (rd_grant)  begin n_grant++;  if (rd_pkts > 0) rd_pkts--; end
      if (busy_tb) begin
        if (lat_ctr == 0) begin
          ctrl_done = 1'b1; busy_tb = 0;
          if (cmd_code == 3'd1) init_open = 0;
        end else lat_ctr--;
      end
    end
  end

  task automatic do_reset(input int interval, input int lat);
    @(negedge clk);
    rst = 1'b1;
    refresh_interval = CNT_W'(interval);
    lat_cfg = lat;
    wr_pkts = 0; rd_pkts = 0;
    repeat (3) @(negedge clk);
    issued_q.delete(); refresh_cyc.delete();
    early_cmds = 0; n_permit = 0; n_grant = 0;
    wr_beats_seen = -1; rd_beats_seen = -1;
  endtask

  initial begin
    // R1: reset state
    do_reset(1000, 10);
    chk(cmd_valid == 1'b0, "R1 valid in reset", int'(cmd_valid), 0);
    chk(cmd_code == 3'd0, "R1 code in reset", int'(cmd_code), 0);
    chk(cmd_beats == '0, "R1 beats in reset", int'(cmd_beats), 0);
    chk(wr_permit == 1'b0 && rd_grant == 1'b0, "R1 permit/grant in reset", int'(wr_permit | rd_grant), 0);

    // R2 R3 R4 R7 R8: requests pending during a slow init
    wr_pkts = 2; rd_pkts = 2;
    rst = 1'b0;
    @(negedge clk);
    chk(cmd_valid && cmd_code == 3'd1, "R2 init strobe right after reset", int'(cmd_code), 1);
    repeat (120) @(negedge clk);
    chk(issued_q.size() == 5, "R4 command count", issued_q.size(), 5);
    if (issued_q.size() == 5) begin
      chk(issued_q[0] == 1, "R2 first command", issued_q[0], 1);
      chk(issued_q[1] == 3, "R4 write before read", issued_q[1], 3);
      chk(issued_q[2] == 3, "R4 second write", issued_q[2], 3);
      chk(issued_q[3] == 4, "R4 read after writes", issued_q[3], 4);
      chk(issued_q[4] == 4, "R4 second read", issued_q[4], 4);
    end
    chk(early_cmds == 0, "R3 commands before init done", early_cmds, 0);
    chk(n_permit == 2, "R7 permit pulses", n_permit, 2);
    chk(wr_beats_seen == PKT_BEATS, "R7 write burst", wr_beats_seen, PKT_BEATS);
    chk(n_grant == 2, "R8 grant pulses", n_grant, 2);
    chk(rd_beats_seen == RD_BEATS, "R8 read burst", rd_beats_seen, RD_BEATS);

    // R4: refresh, write and read all pending at the first decision
    do_reset(30, 40);
    wr_pkts = 1; rd_pkts = 1;
    rst = 1'b0;
    repeat (60) @(negedge clk);
    lat_cfg = 2;
    repeat (40) @(negedge clk);
    chk(issued_q.size() >= 4, "R4 command count", issued_q.size(), 4);
    if (issued_q.size() >= 4) begin
      chk(issued_q[1] == 2, "R4 refresh wins", issued_q[1], 2);
      chk(issued_q[2] == 3, "R4 write next", issued_q[2], 3);
      chk(issued_q[3] == 4, "R4 read last", issued_q[3], 4);
    end

    // R10: nothing pending stays idle
    do_reset(5000, 1);
    rst = 1'b0;
    repeat (100) @(negedge clk);
    chk(issued_q.size() == 1, "R10 only init issued", issued_q.size(), 1);
    chk(cmd_code == 3'd0 && !cmd_valid, "R10 idle code", int'(cmd_code), 0);

    // R9: refresh spacing with completion latency d=2
    do_reset(40, 2);
    rst = 1'b0;
    repeat (300) @(negedge clk);
    chk(refresh_cyc.size() >= 4, "R9 refresh count", refresh_cyc.size(), 4);
    for (int i = 1; i < refresh_cyc.size(); i++)
      chk(refresh_cyc[i] - refresh_cyc[i-1] == 44, "R9 refresh gap",
          refresh_cyc[i] - refresh_cyc[i-1], 44);

    // R6 R7: back-to-back writes with zero-latency completion
    do_reset(5000, 0);
    wr_pkts = 4;
    rst = 1'b0;
    repeat (40) @(negedge clk);
    chk(n_permit == 4, "R7 permits with zero latency", n_permit, 4);
    chk(issued_q.size() == 5, "R6 commands with zero latency", issued_q.size(), 5);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(8 * 20000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule